// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack

This block holds eight 80-bit registers, and each register carries a 2-bit state tag. The same storage can be reached in two ways. In stack mode, every operand is named relative to a 3-bit top pointer. Push and pop move that pointer around the ring of eight, and the block classifies each value written so that the tags always describe the contents. In flat mode, the registers form a directly indexed file of 64-bit packed-integer words, using the low 64 bits of each entry.

The block accepts at most one operation per clock. The results, the overflow and underflow pulses, the pointer and the tags are all registered. A caller sees every effect of an operation at the rising edge that accepts it. A push into an occupied slot, or a read or pop of an empty slot, is refused and flagged, and the stored state is left as it was. A single command marks every entry empty.

Top module: `fstk_regfile`

## Requirements
- R1: After reset, the pointer is 0, every tag is 11 (empty), and rvalid, overflow, underflow and rdata are all 0.
- R2: A push (op_code 1) first decrements the pointer modulo 8, so 0 wraps to 7. It then writes wdata into the entry the new pointer names.
- R3: The tag of a value written in stack mode is derived from the value. Sign bit 79 plays no part. The tag is 01 (zero) when exponent bits 78:64 and mantissa bits 63:0 are all zero, 10 (special) when the exponent is all ones, and 00 (valid) otherwise. Tag 11 means empty.
- R4: A push whose target entry is not empty raises overflow for one cycle. The pointer, the tags and the data stay unchanged.
- R5: A pop (op_code 2) returns the top entry on rdata with rvalid high. It then tags that entry empty and increments the pointer modulo 8.
- R6: A pop, or a stack read, of an empty entry raises underflow for one cycle with rvalid low. The pointer and the tags stay unchanged.
- R7: A stack read (op_code 3) returns physical entry (pointer + idx) mod 8. A stack write (op_code 4) replaces that entry and sets its tag as in R3, whatever the old tag was.
- R8: A flat write (op_code 6) stores wdata[63:0] in bits 63:0 of physical entry idx and sets bits 79:64 to all ones. It also sets the pointer to 0 and tags all eight entries 00.
- R9: A flat read (op_code 5) returns bits 63:0 of physical entry idx, with rdata[79:64] zero and rvalid high. The tag is not checked, so an empty entry raises no underflow.
- R10: The clear command (op_code 7) tags every entry 11. It leaves the pointer and the register contents unchanged.
- R11: rvalid, overflow and underflow are pulses lasting one cycle, registered at the edge that accepts the operation. They are low after a cycle with op_valid low or op_code 0, and rdata holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 none, 1 push, 2 pop, 3 stack read, 4 stack write, 5 flat read, 6 flat write, 7 clear |
| idx | input | 3 | Stack-relative index (stack ops) or physical index (flat ops) |
| wdata | input | 80 | Write data |
| rdata | output | 80 | Read result, held between reads |
| rvalid | output | 1 | rdata updated by this cycle's operation |
| overflow | output | 1 | Push refused, target occupied |
| underflow | output | 1 | Read or pop refused, entry empty |
| top | output | 3 | Current top-of-stack pointer |
| tags | output | 16 | Tag of physical entry i on bits 2i+1:2i |

## Verification
The pointer and the tags are outputs, so a wrong pointer step or a tag update that went astray shows up one edge after the operation that caused it. A corrupted data word stays hidden until it is read back. A stack read or a pop shows it through the pointer arithmetic, and a flat read shows it through the physical index. For that reason, the stimulus reads entries back in both modes after every kind of write. A wrong occupancy decision shows up as a spurious or a missing overflow or underflow pulse, and as a pointer that moved or stayed when it should not have. The sequence wraps the pointer through 0 and fills all eight slots so that both refusals occur.

// File: rtl/fstk_pkg.sv
package fstk_pkg;

    localparam int NREG  = 8;
    localparam int IDXW  = $clog2(NREG);
    localparam int DW    = 80;
    localparam int MW    = 64;
    localparam int EW    = 15;
    localparam int TW    = 2;
    localparam int PADW  = DW - MW;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_PUSH    = 3'd1,
        OP_POP     = 3'd2,
        OP_RD_ST   = 3'd3,
        OP_WR_ST   = 3'd4,
        OP_RD_FLAT = 3'd5,
        OP_WR_FLAT = 3'd6,
        OP_CLEAR   = 3'd7
    } op_e;

    localparam logic [TW-1:0] TAG_VALID   = 2'b00;
    localparam logic [TW-1:0] TAG_ZERO    = 2'b01;
    localparam logic [TW-1:0] TAG_SPECIAL = 2'b10;
    localparam logic [TW-1:0] TAG_EMPTY   = 2'b11;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic [NREG-1:0][TW-1:0] tags;
        logic [IDXW-1:0]         top;
        logic [DW-1:0]           rdata;
        logic                    rvalid;
        logic                    ovf;
        logic                    unf;
    } state_t;

endpackage

// File: rtl/fstk_tagger.sv
module fstk_tagger
    import fstk_pkg::*;
(
    input  logic [DW-1:0] value,
    output logic [TW-1:0] tag
);
    logic [EW-1:0] expo;
    logic [MW-1:0] mant;

    assign expo = value[DW-2 -: EW];
    assign mant = value[MW-1:0];

    always_comb begin
        if (expo == '1)
            tag = TAG_SPECIAL;
        else if (expo == '0 && mant == '0)
            tag = TAG_ZERO;
        else
            tag = TAG_VALID;
    end
endmodule

// File: rtl/fstk_ptr.sv
module fstk_ptr #(
    parameter int NREG = 8,
    parameter int IDXW = $clog2(NREG)
) (
    input  logic [IDXW-1:0] top,
    input  logic [IDXW-1:0] rel,
    output logic [IDXW-1:0] rel_phys,
    output logic [IDXW-1:0] push_phys,
    output logic [IDXW-1:0] pop_phys
);
    localparam logic [IDXW-1:0] ONE = IDXW'(1);

    // Ring arithmetic: the width truncation gives modulo NREG for power-of-two depths
    assign rel_phys  = top + rel;
    assign push_phys = top - ONE;
    assign pop_phys  = top + ONE;
endmodule

// File: rtl/fstk_rdsel.sv
module fstk_rdsel #(
    parameter int N  = 8,
    parameter int W  = 80,
    parameter int SW = $clog2(N)
) (
    input  logic [N-1:0][W-1:0] entries,
    input  logic [SW-1:0]       sel,
    output logic [W-1:0]        q
);
    logic [N-1:0][W-1:0] masked;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_mask
            assign masked[g] = (sel == SW'(g)) ? entries[g] : '0;
        end
    endgenerate

    always_comb begin
        q = '0;
        for (int i = 0; i < N; i++) begin
            q = q | masked[i];
        end
    end
endmodule

// File: rtl/fstk_regfile.sv
module fstk_regfile
    import fstk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [2:0]          op_code,
    input  logic [IDXW-1:0]     idx,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic                rvalid,
    output logic                overflow,
    output logic                underflow,
    output logic [IDXW-1:0]     top,
    output logic [NREG*TW-1:0]  tags
);
    state_t s_d, s_q;

    logic [IDXW-1:0] rel_phys_d, push_phys_d, pop_phys_d;
    logic [DW-1:0]   top_word_d, rel_word_d, flat_word_d;
    logic [TW-1:0]   wtag_d;

    fstk_ptr #(.NREG(NREG), .IDXW(IDXW)) u_ptr (
        .top       (s_q.top),
        .rel       (idx),
        .rel_phys  (rel_phys_d),
        .push_phys (push_phys_d),
        .pop_phys  (pop_phys_d)
    );

    fstk_tagger u_tag (
        .value (wdata),
        .tag   (wtag_d)
    );

    fstk_rdsel #(.N(NREG), .W(DW), .SW(IDXW)) u_rd_top (
        .entries (s_q.regs),
        .sel     (s_q.top),
        .q       (top_word_d)
    );

    fstk_rdsel #(.N(NREG), .W(DW), .SW(IDXW)) u_rd_rel (
        .entries (s_q.regs),
        .sel     (rel_phys_d),
        .q       (rel_word_d)
    );

    fstk_rdsel #(.N(NREG), .W(DW), .SW(IDXW)) u_rd_flat (
        .entries (s_q.regs),
        .sel     (idx),
        .q       (flat_word_d)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        s_d.ovf    = 1'b0;
        s_d.unf    = 1'b0;

        if (op_valid) begin
            case (op_code)
                OP_PUSH: begin
                    if (s_q.tags[push_phys_d] != TAG_EMPTY) begin
                        s_d.ovf = 1'b1;
                    end else begin
                        s_d.regs[push_phys_d] = wdata;
                        s_d.tags[push_phys_d] = wtag_d;
                        s_d.top               = push_phys_d;
                    end
                end
                OP_POP: begin
                    if (s_q.tags[s_q.top] == TAG_EMPTY) begin
                        s_d.unf = 1'b1;
                    end else begin
                        s_d.rdata           = top_word_d;
                        s_d.rvalid          = 1'b1;
                        s_d.tags[s_q.top]   = TAG_EMPTY;
                        s_d.top             = pop_phys_d;
                    end
                end
                OP_RD_ST: begin
                    if (s_q.tags[rel_phys_d] == TAG_EMPTY) begin
                        s_d.unf = 1'b1;
                    end else begin
                        s_d.rdata  = rel_word_d;
                        s_d.rvalid = 1'b1;
                    end
                end
                OP_WR_ST: begin
                    s_d.regs[rel_phys_d] = wdata;
                    s_d.tags[rel_phys_d] = wtag_d;
                end
                OP_RD_FLAT: begin
                    s_d.rdata  = {{PADW{1'b0}}, flat_word_d[MW-1:0]};
                    s_d.rvalid = 1'b1;
                end
                OP_WR_FLAT: begin
                    s_d.regs[idx] = {{PADW{1'b1}}, wdata[MW-1:0]};
                    s_d.top       = '0;
                    for (int i = 0; i < NREG; i++) begin
                        s_d.tags[i] = TAG_VALID;
                    end
                end
                OP_CLEAR: begin
                    for (int i = 0; i < NREG; i++) begin
                        s_d.tags[i] = TAG_EMPTY;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.regs   <= '0;
            for (int i = 0; i < NREG; i++) begin
                s_q.tags[i] <= TAG_EMPTY;
            end
            s_q.top    <= '0;
            s_q.rdata  <= '0;
            s_q.rvalid <= 1'b0;
            s_q.ovf    <= 1'b0;
            s_q.unf    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata     = s_q.rdata;
    assign rvalid    = s_q.rvalid;
    assign overflow  = s_q.ovf;
    assign underflow = s_q.unf;
    assign top       = s_q.top;
    assign tags      = s_q.tags;
endmodule

// File: rtl/fstk_checker.sv
module fstk_checker
    import fstk_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                op_valid,
    input logic [2:0]          op_code,
    input logic [IDXW-1:0]     top,
    input logic [NREG*TW-1:0]  tags,
    input logic                rvalid,
    input logic                overflow,
    input logic                underflow
);
    // R4
    ovf_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (top == $past(top) && tags == $past(tags)));

    // R6
    unf_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (top == $past(top) && tags == $past(tags) && !rvalid));

    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && $past(op_code) == OP_PUSH && !overflow)
        |-> top == IDXW'($past(top) - IDXW'(1)));

    // R5
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && $past(op_code) == OP_POP && !underflow)
        |-> (top == IDXW'($past(top) + IDXW'(1)) && rvalid));

    // R8
    flat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && $past(op_code) == OP_WR_FLAT)
        |-> (top == '0 && tags == '0));

    // R10
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && $past(op_code) == OP_CLEAR)
        |-> (tags == '1 && top == $past(top)));

    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_valid)) |-> (!rvalid && !overflow && !underflow));
endmodule

bind fstk_regfile fstk_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .top       (top),
    .tags      (tags),
    .rvalid    (rvalid),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/fstk_regfile_tb.sv
`timescale 1ns/100ps
module fstk_regfile_tb;
    import fstk_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [2:0] idx = 3'd0;
    logic [79:0] wdata = '0;
    logic [79:0] rdata;
    logic rvalid, overflow, underflow;
    logic [2:0] top;
    logic [15:0] tags;

    always #2.5 clk = ~clk;

    fstk_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .idx(idx), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .overflow(overflow), .underflow(underflow), .top(top), .tags(tags)
    );

    typedef struct {
        string       req;
        logic [79:0] rdata;
        logic        rvalid;
        logic        ovf;
        logic        unf;
        logic [2:0]  top;
        logic [15:0] tags;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // reference state built from the requirements
    logic [79:0] m_reg[8];
    logic [1:0]  m_tag[8];
    logic [2:0]  m_top;
    logic [79:0] m_rdata;

    function automatic logic [1:0] classify(input logic [79:0] v);
        if (v[78:64] == 15'h7FFF) return 2'b10;
        if (v[78:64] == 15'h0 && v[63:0] == 64'h0) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [15:0] pack_tags();
        logic [15:0] t;
        for (int i = 0; i < 8; i++) t[2*i +: 2] = m_tag[i];
        return t;
    endfunction

    task automatic do_op(input logic [2:0] op, input logic [2:0] ix,
                         input logic [79:0] wd, input string req);
        exp_t e;
        logic [2:0] p;
        e.req = req; e.rvalid = 1'b0; e.ovf = 1'b0; e.unf = 1'b0;
        @(negedge clk);
        op_valid = (op != 3'd0);
        op_code = op; idx = ix; wdata = wd;
        case (op)
            3'd1: begin
                p = m_top - 3'd1;
                if (m_tag[p] != 2'b11) e.ovf = 1'b1;
                else begin m_reg[p] = wd; m_tag[p] = classify(wd); m_top = p; end
            end
            3'd2: begin
                if (m_tag[m_top] == 2'b11) e.unf = 1'b1;
                else begin
                    m_rdata = m_reg[m_top]; e.rvalid = 1'b1;
                    m_tag[m_top] = 2'b11; m_top = m_top + 3'd1;
                end
            end
            3'd3: begin
                p = m_top + ix;
                if (m_tag[p] == 2'b11) e.unf = 1'b1;
                else begin m_rdata = m_reg[p]; e.rvalid = 1'b1; end
            end
            3'd4: begin
                p = m_top + ix;
                m_reg[p] = wd; m_tag[p] = classify(wd);
            end
            3'd5: begin m_rdata = {16'h0, m_reg[ix][63:0]}; e.rvalid = 1'b1; end
            3'd6: begin
                m_reg[ix] = {16'hFFFF, wd[63:0]}; m_top = 3'd0;
                for (int i = 0; i < 8; i++) m_tag[i] = 2'b00;
            end
            3'd7: for (int i = 0; i < 8; i++) m_tag[i] = 2'b11;
            default: ;
        endcase
        e.rdata = m_rdata; e.top = m_top; e.tags = pack_tags();
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // monitor: compares one expected item per accepting edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (rdata !== e.rdata || rvalid !== e.rvalid || overflow !== e.ovf ||
                    underflow !== e.unf || top !== e.top || tags !== e.tags) begin
                    fails++;
                    $display("FAIL %s: act rdata=%h rv=%b ovf=%b unf=%b top=%0d tags=%h | exp rdata=%h rv=%b ovf=%b unf=%b top=%0d tags=%h",
                             e.req, rdata, rvalid, overflow, underflow, top, tags,
                             e.rdata, e.rvalid, e.ovf, e.unf, e.top, e.tags);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog: act running exp finished");
        finish_run();
    end

    localparam logic [79:0] VA = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0001};
    localparam logic [79:0] VZ = {1'b1, 79'h0};
    localparam logic [79:0] VS = {1'b0, 15'h7FFF, 64'hC000_0000_0000_0000};
    localparam logic [79:0] VX = {1'b0, 15'h4001, 64'hA5A5_5A5A_0F0F_F0F0};

    initial begin
        for (int i = 0; i < 8; i++) begin m_reg[i] = '0; m_tag[i] = 2'b11; end
        m_top = 3'd0; m_rdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (top !== 3'd0 || tags !== 16'hFFFF || rvalid !== 1'b0 || overflow !== 1'b0 ||
            underflow !== 1'b0 || rdata !== '0) begin
            fails++;
            $display("FAIL R1: act top=%0d tags=%h rv=%b ovf=%b unf=%b rdata=%h exp top=0 tags=ffff rest 0",
                     top, tags, rvalid, overflow, underflow, rdata);
        end
        rst_n = 1'b1;
        do_op(3'd1, 3'd0, VA, "R2 push wraps 0 to 7, valid tag R3");
        do_op(3'd1, 3'd0, VZ, "R3 zero tag, sign ignored");
        do_op(3'd1, 3'd0, VS, "R3 special tag");
        do_op(3'd3, 3'd1, '0, "R7 stack read ST(1)");
        do_op(3'd2, 3'd0, '0, "R5 pop special");
        do_op(3'd4, 3'd0, VX, "R7 stack write ST(0)");
        do_op(3'd3, 3'd0, '0, "R7 read back ST(0)");
        do_op(3'd3, 3'd2, '0, "R6 read of empty entry");
        do_op(3'd0, 3'd0, '0, "R11 idle quiet");
        for (int k = 0; k < 6; k++)
            do_op(3'd1, 3'd0, {1'b0, 15'(16'h4000 + k), 64'(k * 17 + 3)}, "R2 fill push");
        do_op(3'd1, 3'd0, VA, "R4 push into occupied");
        do_op(3'd3, 3'd7, '0, "R7 read ST(7) wraps");
        do_op(3'd5, 3'd3, '0, "R9 flat read");
        do_op(3'd7, 3'd0, '0, "R10 clear all");
        do_op(3'd5, 3'd7, '0, "R10 data kept, R9 no tag check");
        do_op(3'd2, 3'd0, '0, "R6 pop of empty");
        do_op(3'd6, 3'd2, 80'h1234_DEAD_BEEF_0BAD_F00D, "R8 flat write");
        do_op(3'd3, 3'd2, '0, "R8 upper ones via stack read");
        do_op(3'd5, 3'd2, '0, "R9 flat read masks upper");
        do_op(3'd1, 3'd0, VX, "R4 push after flat write");
        do_op(3'd2, 3'd0, '0, "R5 pop after flat write");
        do_op(3'd0, 3'd0, '0, "R11 idle, rdata held");
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule